// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a single 32-bit down-counter with a word-addressed register port. It runs on the system clock. A tick-enable input, divided by a selectable prescaler, sets the rate at which it counts. Software selects one of three counting modes and a 16- or 32-bit counter width through a control register:

- **Free-running** wraps from zero to the all-ones value of the chosen width.
- **Periodic** reloads from a programmed limit on each expiry.
- **One-shot** stops at zero.

Each expiry sets a raw interrupt flag. A level interrupt output presents that flag when the interrupt enable is set.

Software has two ways to program the limit. The immediate path stores the limit and restarts the count from it at once. The background path only replaces the stored limit, which the counter picks up at its next natural reload. This lets the period change without a phase jump. Register reads are registered: data requested in one cycle is on `rdata` after the next rising edge.

Top module: `dtimer_core`

## Requirements
- R1: After reset the control register reads 0x20 (only interrupt enable set, stopped, mode bits zero), the count reads 0x0000FFFF, the limit reads 0, the raw flag reads 0 and `irq` is low.
- R2: The word index is `addr[7:2]`. Index 0 is the immediate load, 1 the current count (read-only), 2 control, 3 interrupt clear (write-only), 4 raw status, 5 masked status and 6 the background load. Reading any other index returns 0. A read issued with `rd_en` in one cycle appears on `rdata` after the next rising edge.
- R3: A write to index 0 stores the limit and reloads the count at once with the mode's reload value. Indices 0 and 6 both read back the stored limit.
- R4: A write to index 6 stores the limit and leaves the current count untouched. The new limit is used from the next reload onwards.
- R5: The control fields are: bit 0 one-shot, bit 1 32-bit width, bits [3:2] prescale code, bit 4 spare (stored), bit 5 interrupt enable, bit 6 periodic and bit 7 run. Only bits [7:0] are stored. A control write with bit 7 set reloads the count with the new mode's reload value. A control write with bit 7 clear leaves the count unchanged and stops counting.
- R6: Prescale code 01 makes one count step per 16 ticks, code 10 one per 256 ticks, and codes 00 and 11 one per tick. Any write to index 0 or 2 restarts the prescaler.
- R7: In periodic mode (bit 6 set, bit 0 clear), a step taken at count 0 reloads the count from the limit and sets the raw flag, so expiries are (limit+1) steps apart.
- R8: With bits 0 and 6 both clear the timer is free-running. It reloads with 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, and ignores the stored limit.
- R9: In one-shot mode (bit 0 set), a step at count 0 sets the raw flag, holds the count at 0 and clears the run bit of the control register.
- R10: In 16-bit mode only the low 16 bits of the count and of the reload value are used. The upper 16 bits of the count read as zero.
- R11: Any write to index 3 clears the raw flag. An expiry in the same cycle takes priority and leaves the flag set.
- R12: The masked status reads the raw flag when interrupt enable is set and 0 otherwise. `irq` always equals the raw flag ANDed with interrupt enable.
- R13: Writes to index 1 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| tick | input | 1 | Count-enable pulse before prescaling |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, raw flag ANDed with enable |

## Verification
A corrupted count or a prescaler that loses its phase is visible at the ports as an interrupt edge arriving on the wrong tick. The bench therefore measures, for every prescale code and several small limits, the exact tick number at which `irq` rises, on both the first and the following period. A wrong stored limit or mode shows up within one read cycle as a wrong value on index 0, 1 or 2. A one-shot counter that fails to stop shows up as a nonzero count a few ticks after expiry.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  parameter int TMR_W  = 32;
  parameter int HALF_W = 16;

  // register word indices
  localparam int IDX_LOAD   = 0;
  localparam int IDX_VALUE  = 1;
  localparam int IDX_CTRL   = 2;
  localparam int IDX_CLR    = 3;
  localparam int IDX_RAW    = 4;
  localparam int IDX_MASKED = 5;
  localparam int IDX_BGLOAD = 6;

  // packed so that each field lands on the bit the control word defines
  typedef struct packed {
    logic       run;       // bit 7
    logic       periodic;  // bit 6
    logic       ie;        // bit 5
    logic       spare;     // bit 4
    logic [1:0] presc;     // bits 3:2
    logic       wide;      // bit 1
    logic       oneshot;   // bit 0
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{run: 1'b0, periodic: 1'b0, ie: 1'b1,
                                 spare: 1'b0, presc: 2'b00, wide: 1'b0,
                                 oneshot: 1'b0};

  function automatic logic [TMR_W-1:0] width_mask(input logic wide);
    return wide ? {TMR_W{1'b1}} : {{(TMR_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  endfunction

  // value loaded on any reload, chosen by mode and width
  function automatic logic [TMR_W-1:0] mode_limit(input ctrl_t c,
                                                  input logic [TMR_W-1:0] lim);
    if (!c.oneshot && !c.periodic) return width_mask(c.wide);
    return lim & width_mask(c.wide);
  endfunction

endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale #(
  parameter int STEP_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] code_i,
  output logic       step_o
);
  localparam int PRE_W = 2 * STEP_LOG2;

  logic [PRE_W-1:0] pre_q;
  logic             term;

  always_comb begin
    case (code_i)
      2'b01:   term = &pre_q[STEP_LOG2-1:0];
      2'b10:   term = &pre_q;
      default: term = 1'b1;
    endcase
  end

  assign step_o = run_i & tick_i & term;

  always_ff @(posedge clk) begin
    if (rst || clr_i)        pre_q <= '0;
    else if (run_i && tick_i) pre_q <= pre_q + 1'b1;
  end

  // R6: without a tick no step may leave the prescaler
  a_r6_step_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_i |-> !step_o);

endmodule

// File: rtl/dtmr_count.sv
module dtmr_count
  import dtmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl_i,
  input  logic [TMR_W-1:0] limit_i,
  input  logic             step_i,
  input  logic             reload_i,
  input  logic [TMR_W-1:0] reload_val_i,
  output logic [TMR_W-1:0] count_o,
  output logic             expire_o,
  output logic             oneshot_done_o
);
  localparam logic [TMR_W-1:0] CNT_RST = mode_limit(CTRL_RST, '0);

  logic [TMR_W-1:0] count_q;
  logic [TMR_W-1:0] cnt_eff;

  assign cnt_eff        = count_q & width_mask(ctrl_i.wide);
  assign count_o        = cnt_eff;
  assign expire_o       = step_i & (cnt_eff == '0) & ~reload_i;
  assign oneshot_done_o = expire_o & ctrl_i.oneshot;

  always_ff @(posedge clk) begin
    if (rst)                 count_q <= CNT_RST;
    else if (reload_i)       count_q <= reload_val_i;
    else if (expire_o)       count_q <= ctrl_i.oneshot ? '0 : mode_limit(ctrl_i, limit_i);
    else if (step_i)         count_q <= cnt_eff - 1'b1;
  end

  // R9: after a one-shot expiry the count sits at zero
  a_r9_oneshot_holds: assert property (@(posedge clk) disable iff (rst)
    oneshot_done_o |=> (count_o == '0));

  // R5: stopped timer with no reload keeps its count
  a_r5_stopped_stable: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_i.run && !reload_i) |=> $stable(count_q));

endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TMR_W-1:0]  wdata,
  input  logic [TMR_W-1:0]  count_i,
  input  logic              expire_i,
  input  logic              oneshot_done_i,
  output ctrl_t             ctrl_o,
  output logic [TMR_W-1:0]  limit_o,
  output logic              reload_o,
  output logic [TMR_W-1:0]  reload_val_o,
  output logic              presc_clr_o,
  output logic              raw_o,
  output logic [TMR_W-1:0]  rdata_o
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]    idx;
  logic             wr_load, wr_ctrl, wr_clr, wr_bg;
  ctrl_t            ctrl_q, ctrl_new;
  logic [TMR_W-1:0] limit_q;
  logic             raw_q;
  logic [TMR_W-1:0] rd_mux;

  assign idx      = addr[ADDR_W-1:2];
  assign wr_load  = wr_en && (idx == IW'(IDX_LOAD));
  assign wr_ctrl  = wr_en && (idx == IW'(IDX_CTRL));
  assign wr_clr   = wr_en && (idx == IW'(IDX_CLR));
  assign wr_bg    = wr_en && (idx == IW'(IDX_BGLOAD));
  assign ctrl_new = ctrl_t'(wdata[7:0]);

  assign reload_o     = wr_load | (wr_ctrl & ctrl_new.run);
  assign reload_val_o = wr_load ? mode_limit(ctrl_q, wdata)
                                : mode_limit(ctrl_new, limit_q);
  assign presc_clr_o  = wr_load | wr_ctrl;

  always_ff @(posedge clk) begin
    if (rst)                 ctrl_q <= CTRL_RST;
    else if (wr_ctrl)        ctrl_q <= ctrl_new;
    else if (oneshot_done_i) ctrl_q.run <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                  limit_q <= '0;
    else if (wr_load || wr_bg) limit_q <= wdata;
  end

  // expiry has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)           raw_q <= 1'b0;
    else if (expire_i) raw_q <= 1'b1;
    else if (wr_clr)   raw_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (idx)
      IW'(IDX_LOAD), IW'(IDX_BGLOAD): rd_mux = limit_q;
      IW'(IDX_VALUE):  rd_mux = count_i;
      IW'(IDX_CTRL):   rd_mux = {{(TMR_W-8){1'b0}}, ctrl_q};
      IW'(IDX_RAW):    rd_mux = {{(TMR_W-1){1'b0}}, raw_q};
      IW'(IDX_MASKED): rd_mux = {{(TMR_W-1){1'b0}}, raw_q & ctrl_q.ie};
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end

  assign ctrl_o  = ctrl_q;
  assign limit_o = limit_q;
  assign raw_o   = raw_q;

  // R11: a clear with no competing expiry drops the flag
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_clr && !expire_i) |=> !raw_q);

  // R11: expiry wins and the flag is set next cycle
  a_r11_expire_sets: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> raw_q);

  // R9: one-shot expiry turns the run bit off
  a_r9_run_cleared: assert property (@(posedge clk) disable iff (rst)
    (oneshot_done_i && !wr_ctrl) |=> !ctrl_q.run);

  // R13: a write to the value index leaves limit and control alone
  a_r13_value_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == IW'(IDX_VALUE)) |=> ($stable(limit_q) && (ctrl_q.ie == $past(ctrl_q.ie))));

endmodule

// File: rtl/dtimer_core.sv
module dtimer_core
  import dtmr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int STEP_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TMR_W-1:0]  wdata,
  input  logic              tick,
  output logic [TMR_W-1:0]  rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [TMR_W-1:0] limit, reload_val, count;
  logic             reload, presc_clr, step, expire, oneshot_done, raw;

  dtmr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count_i(count), .expire_i(expire),
    .oneshot_done_i(oneshot_done), .ctrl_o(ctrl), .limit_o(limit),
    .reload_o(reload), .reload_val_o(reload_val), .presc_clr_o(presc_clr),
    .raw_o(raw), .rdata_o(rdata)
  );

  dtmr_prescale #(.STEP_LOG2(STEP_LOG2)) u_presc (
    .clk(clk), .rst(rst), .clr_i(presc_clr), .run_i(ctrl.run),
    .tick_i(tick), .code_i(ctrl.presc), .step_o(step)
  );

  dtmr_count u_count (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .limit_i(limit), .step_i(step),
    .reload_i(reload), .reload_val_i(reload_val), .count_o(count),
    .expire_o(expire), .oneshot_done_o(oneshot_done)
  );

  assign irq = raw & ctrl.ie;

  // R1: the interrupt is quiet in the first cycle after reset
  a_r1_irq_after_reset: assert property (@(posedge clk)
    rst |=> !irq);

endmodule

// File: tb/dtimer_core_test.sv
module dtimer_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] ONE = 32'h01, WIDE = 32'h02, IE = 32'h20,
                          PER = 32'h40, RUN = 32'h80;

  dtimer_core uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .tick(tick), .rdata(rdata),
                   .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 8'(idx * 4); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = 8'(idx * 4);
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic measure(output int n);
    @(negedge clk); tick = 1'b1; n = 0;
    for (int k = 0; k < 70000; k++) begin
      @(negedge clk); n++;
      if (irq) break;
    end
    tick = 1'b0;
  endtask

  task automatic pulse_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n, div;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", {31'b0, irq}, 0);
    rd(2, v); chk("R1 ctrl", v, 32'h20);
    rd(1, v); chk("R1 value", v, 32'hFFFF);
    rd(0, v); chk("R1 limit", v, 0);
    rd(4, v); chk("R1 raw", v, 0);
    rd(7, v); chk("R2 unmapped", v, 0);
    rd(40, v); chk("R2 far index", v, 0);

    // R6 R7 sweep over prescale codes and small limits, two periods each
    for (int code = 0; code < 4; code++) begin
      div = (code == 1) ? 16 : (code == 2) ? 256 : 1;
      for (int lim = 0; lim < 4; lim++) begin
        wr(2, 0);
        wr(0, lim);
        wr(2, RUN | PER | IE | WIDE | (32'(code) << 2));
        wr(3, 0);
        measure(n); chk("R6 first period", n, (lim + 1) * div);
        wr(3, 0);
        measure(n); chk("R7 second period", n, (lim + 1) * div);
      end
    end

    // R8 free-running 16-bit
    wr(2, 0);
    wr(0, 5);
    rd(1, v); chk("R8 free load ignored", v, 32'hFFFF);
    rd(0, v); chk("R3 limit stored", v, 5);
    wr(2, RUN | IE);
    wr(3, 0);
    measure(n); chk("R8 16-bit wrap", n, 65536);
    rd(1, v); chk("R8 reload ffff", v, 32'hFFFF);

    // R8 free-running 32-bit
    wr(2, RUN | WIDE);
    rd(1, v); chk("R8 32-bit reload", v, 32'hFFFFFFFF);
    pulse_ticks(1);
    rd(1, v); chk("R8 32-bit step", v, 32'hFFFFFFFE);

    // R5 stop keeps count
    wr(2, WIDE);
    rd(1, v); chk("R5 stop unchanged", v, 32'hFFFFFFFE);
    pulse_ticks(5);
    rd(1, v); chk("R5 stopped no count", v, 32'hFFFFFFFE);

    // R13 value write ignored
    wr(1, 32'h1234);
    rd(1, v); chk("R13 value write", v, 32'hFFFFFFFE);

    // R5 field storage
    wr(2, 32'hFFFF_FF5C);
    rd(2, v); chk("R5 ctrl low byte", v, 32'h5C);

    // R3 immediate load
    wr(2, PER | WIDE);
    wr(0, 9);
    rd(1, v); chk("R3 immediate count", v, 9);
    rd(6, v); chk("R3 bg index reads limit", v, 9);

    // R4 background load
    wr(0, 3);
    wr(2, RUN | PER | IE | WIDE);
    wr(6, 6);
    rd(1, v); chk("R4 count untouched", v, 3);
    rd(0, v); chk("R4 limit updated", v, 6);
    wr(3, 0);
    measure(n); chk("R4 old period", n, 4);
    wr(3, 0);
    measure(n); chk("R4 new period", n, 7);

    // R9 one-shot
    wr(2, 0);
    wr(0, 2);
    wr(2, RUN | IE | WIDE | ONE);
    wr(3, 0);
    measure(n); chk("R9 expiry", n, 3);
    pulse_ticks(5);
    rd(1, v); chk("R9 holds zero", v, 0);
    rd(2, v); chk("R9 run cleared", v, 32'h23);
    rd(4, v); chk("R9 raw set", v, 1);

    // R12 masking
    wr(2, WIDE);
    chk("R12 irq masked", {31'b0, irq}, 0);
    rd(5, v); chk("R12 masked zero", v, 0);
    rd(4, v); chk("R12 raw kept", v, 1);
    wr(2, WIDE | IE);
    chk("R12 irq shown", {31'b0, irq}, 1);
    rd(5, v); chk("R12 masked one", v, 1);

    // R11 clear, and expiry beating clear
    wr(3, 32'h55);
    rd(4, v); chk("R11 cleared", v, 0);
    chk("R11 irq low", {31'b0, irq}, 0);
    wr(2, 0);
    wr(0, 0);
    wr(2, RUN | PER | IE | WIDE);
    @(negedge clk); tick = 1'b1;
    wr(3, 0);
    tick = 1'b0;
    rd(4, v); chk("R11 expiry wins", v, 1);

    // R10 16-bit width
    wr(2, PER);
    wr(0, 32'h12345);
    rd(1, v); chk("R10 masked count", v, 32'h2345);
    rd(0, v); chk("R10 full limit", v, 32'h12345);
    wr(2, PER | RUN);
    pulse_ticks(1);
    rd(1, v); chk("R10 step low half", v, 32'h2344);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule